// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

A single-port synchronous static memory that can accept a new read or write command on every clock, with no idle cycles needed between a read and a write. Address and control are taken on the rising edge. The data for each command moves two edges later: read data is driven from a register, and write data is sampled from the data-in bus. Because the write path has the same two-cycle offset as the read path, the bus can carry alternating reads and writes at full rate.

The memory has three chip enables and a load/advance control. A load starts a new access at the presented address. An advance steps a two-bit burst counter through a four-word window, in either linear or interleaved order. Each byte lane has its own write strobe. An active-low clock enable freezes the whole pipeline. An asynchronous output enable gates the output-valid flag, which stands in for a tri-state driver.

Top module: `zt_sram`

## Requirements
- R1: For a read command sampled at edge k, `dq_oe` is 1 and `dq_out` holds the addressed word after edge k+2 and before edge k+3.
- R2: For a write command sampled at edge k, the word on `dq_in` is sampled at edge k+2 and stored.
- R3: Reads and writes can be issued on consecutive cycles in any mix. A read issued one or two cycles after a write to the same address returns the newly written word.
- R4: Lane i is bits [9i+8:9i]. A write stores lane i only when `bw_n[i]` is 0; the other lanes keep their contents.
- R5: While `clk_en_n` is 1, all synchronous inputs are ignored, no memory word changes, and every pipeline register, `dq_oe` and `dq_out` included, keeps its value.
- R6: The chip is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 while `load_n`=0. A load under any other combination starts nothing and ends any burst in progress, and `dq_oe` is 0 two edges later. An advance with no active burst does nothing.
- R7: Commands already in the pipeline still complete after a deselect.
- R8: In the output slot of a write command, `dq_oe` is 0.
- R9: With `load_n`=1 during an active burst, the address advances by one step. The step is 0,1,2,3 and then wraps. The two low address bits become (start+step) mod 4 when `burst_ilv`=0, or start XOR step when `burst_ilv`=1. The upper bits and the read/write direction stay the same, and the byte strobes are sampled on every advance.
- R10: `oe_n`=1 forces `dq_oe` to 0 at once without changing the pipeline. When `oe_n` returns to 0, the held data is shown again.
- R11: After reset no operations are pending and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the pipeline |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | 0 loads a new command, 1 advances the burst |
| we_n | input | 1 | 0 selects write, 1 selects read, on load |
| bw_n | input | LANES | Active-low per-lane write strobes |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | LANES*LANE_W | Write data, sampled two edges after its command |
| dq_out | output | LANES*LANE_W | Read data, zero when not valid |
| dq_oe | output | 1 | Output-valid flag (models the bus driver) |

## Verification
A wrong burst step or a wrong latched direction shows up as a wrong word or a wrong `dq_oe` two edges after the bad cycle. A stale enable bit in either pipeline stage makes `dq_oe` rise or fall in the wrong slot, which is visible at the very next edge. A bad lane mask, or a write slipped to the wrong slot, stays hidden until a later read of that address. For that reason the bench reads back every written word and every masked lane. A clock-enable leak changes `dq_out` or memory during a freeze, and the bench catches it on the first enabled read that follows.

// File: rtl/zt_pkg.sv
package zt_pkg;
    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/zt_cmd_stage.sv
module zt_cmd_stage
    import zt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load_n,
    input  logic              sel,
    input  logic              we_n,
    input  logic              burst_ilv,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LANES-1:0]  cmd_bw_n
);
    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  start;
        logic [CNT_W-1:0]  step;
        logic [LANES-1:0]  bw_n;
    } stage_t;

    stage_t       s_d, s_q;
    logic [CNT_W-1:0] step_nx;
    burst_order_e order;

    assign order = burst_order_e'(burst_ilv);

    always_comb begin
        s_d     = s_q;
        step_nx = s_q.step + 1'b1;
        if (!hold) begin
            if (!load_n) begin
                s_d.valid = sel;
                s_d.write = !we_n;
                s_d.addr  = addr;
                s_d.start = addr[CNT_W-1:0];
                s_d.step  = '0;
                s_d.bw_n  = bw_n;
            end else if (s_q.valid) begin
                s_d.step = step_nx;
                s_d.addr[CNT_W-1:0] = (order == ORDER_INTERLEAVE) ?
                                      (s_q.start ^ step_nx) : (s_q.start + step_nx);
                s_d.bw_n = bw_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_valid = s_q.valid;
    assign cmd_write = s_q.write;
    assign cmd_addr  = s_q.addr;
    assign cmd_bw_n  = s_q.bw_n;

    assert_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !load_n && !sel) |=> !cmd_valid);

    assert_advance_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && load_n && cmd_valid) |=>
        (cmd_valid && $stable(cmd_write) && $stable(cmd_addr[ADDR_W-1:CNT_W])));

    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(s_q));
endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    hold,
    input  logic                    op_valid,
    input  logic                    op_write,
    input  logic [ADDR_W-1:0]       op_addr,
    input  logic [LANES-1:0]        op_bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (!hold && op_valid) begin
                if (op_write) begin
                    if (!op_bw_n[g]) mem[op_addr] <= wdata[g*LANE_W +: LANE_W];
                end else begin
                    rd_q <= mem[op_addr];
                end
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    load_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    burst_ilv,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              b_valid;
        logic              b_write;
        logic [ADDR_W-1:0] b_addr;
        logic [LANES-1:0]  b_bw_n;
        logic              drive;
    } pipe_t;

    pipe_t st_d, st_q;
    logic hold, sel;
    logic a_valid, a_write;
    logic [ADDR_W-1:0] a_addr;
    logic [LANES-1:0]  a_bw_n;
    logic [DATA_W-1:0] rdata;

    assign hold = clk_en_n;
    assign sel  = !ce1_n && ce2 && !ce3_n;

    zt_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .hold(hold), .load_n(load_n), .sel(sel),
        .we_n(we_n), .burst_ilv(burst_ilv), .bw_n(bw_n), .addr(addr),
        .cmd_valid(a_valid), .cmd_write(a_write), .cmd_addr(a_addr), .cmd_bw_n(a_bw_n)
    );

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            st_d.b_valid = a_valid;
            st_d.b_write = a_write;
            st_d.b_addr  = a_addr;
            st_d.b_bw_n  = a_bw_n;
            st_d.drive   = st_q.b_valid && !st_q.b_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    zt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .hold(hold), .op_valid(st_q.b_valid), .op_write(st_q.b_write),
        .op_addr(st_q.b_addr), .op_bw_n(st_q.b_bw_n), .wdata(dq_in), .rdata(rdata)
    );

    assign dq_oe  = st_q.drive && !oe_n;
    assign dq_out = dq_oe ? rdata : '0;

    assert_read_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && st_q.b_valid && !st_q.b_write) |=> st_q.drive);

    assert_write_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && st_q.b_valid && st_q.b_write) |=> !st_q.drive);

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(st_q) && $stable(rdata)));

    assert_idle_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !st_q.b_valid) |=> !st_q.drive);
endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
    localparam int AW = 10;
    localparam int DW = 18;
    localparam logic [2:0] SEL = 3'b010; // {ce1_n, ce2, ce3_n}

    typedef struct packed {
        logic [2:0]    ce;
        logic          ld_n;
        logic          wr_n;
        logic [1:0]    bw;
        logic [AW-1:0] a;
        logic [DW-1:0] din;
        logic          eoe;
        logic [DW-1:0] eq;
    } vec_t;

    // Each row: inputs before edge i, expected outputs after edge i.
    localparam vec_t VECS [12] = '{
        '{SEL,    1'b0, 1'b0, 2'b00, 10'd5, 18'h00000, 1'b0, 18'h00000},
        '{SEL,    1'b0, 1'b0, 2'b00, 10'd6, 18'h00000, 1'b0, 18'h00000},
        '{SEL,    1'b0, 1'b1, 2'b11, 10'd5, 18'h12345, 1'b0, 18'h00000},
        '{SEL,    1'b0, 1'b1, 2'b11, 10'd6, 18'h0ABCD, 1'b0, 18'h00000},
        '{SEL,    1'b0, 1'b0, 2'b00, 10'd7, 18'h00000, 1'b1, 18'h12345},
        '{SEL,    1'b0, 1'b0, 2'b10, 10'd5, 18'h00000, 1'b1, 18'h0ABCD},
        '{SEL,    1'b0, 1'b1, 2'b11, 10'd7, 18'h3FFFF, 1'b0, 18'h00000},
        '{SEL,    1'b0, 1'b1, 2'b11, 10'd5, 18'h00111, 1'b0, 18'h00000},
        '{3'b110, 1'b0, 1'b1, 2'b11, 10'd0, 18'h00000, 1'b1, 18'h3FFFF},
        '{3'b011, 1'b0, 1'b1, 2'b11, 10'd0, 18'h00000, 1'b1, 18'h12311},
        '{3'b000, 1'b0, 1'b1, 2'b11, 10'd0, 18'h00000, 1'b0, 18'h00000},
        '{3'b110, 1'b0, 1'b1, 2'b11, 10'd0, 18'h00000, 1'b0, 18'h00000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic load_n = 1'b0, we_n = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
    logic [1:0] bw_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    zt_sram u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .load_n(load_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
        .burst_ilv(burst_ilv), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(string tag, logic eoe, logic [DW-1:0] eq);
        n_chk++;
        if (dq_oe !== eoe || (eoe && dq_out !== eq)) begin
            n_bad++;
            $display("FAIL %s: got oe=%0b q=%05h, expected oe=%0b q=%05h",
                     tag, dq_oe, dq_out, eoe, eq);
        end
    endtask

    task automatic cyc(logic [2:0] ce, logic ld, logic wr, logic [1:0] bw,
                       logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        {ce1_n, ce2, ce3_n} = ce;
        load_n = ld; we_n = wr; bw_n = bw; addr = a; dq_in = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no finish, expected end of run");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset idle", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(3'b110, 1'b0, 1'b1, 2'b11, 10'd0, '0);
        check("R11 first cycle idle", 1'b0, '0);

        // Table: R1 R2 R3 R4 R7 R8 R6
        for (int i = 0; i < 12; i++) begin
            cyc(VECS[i].ce, VECS[i].ld_n, VECS[i].wr_n, VECS[i].bw, VECS[i].a, VECS[i].din);
            check($sformatf("R1/R2/R3/R4/R6/R7/R8 vector %0d", i), VECS[i].eoe, VECS[i].eq);
        end

        // R5: freeze with junk write to address 6
        cyc(SEL, 1'b0, 1'b1, 2'b11, 10'd6, '0);
        clk_en_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc(SEL, 1'b0, 1'b0, 2'b00, 10'd6, 18'h3FFFF);
            check("R5 frozen output stays idle", 1'b0, '0);
        end
        clk_en_n = 1'b0;
        cyc(3'b110, 1'b0, 1'b1, 2'b11, 10'd0, '0);
        check("R5 read not yet out", 1'b0, '0);
        cyc(3'b110, 1'b0, 1'b1, 2'b11, 10'd0, '0);
        check("R5 read after freeze", 1'b1, 18'h0ABCD);
        clk_en_n = 1'b1;
        cyc(SEL, 1'b0, 1'b1, 2'b11, 10'd5, '0);
        check("R5 output held", 1'b1, 18'h0ABCD);
        cyc(SEL, 1'b0, 1'b1, 2'b11, 10'd5, '0);
        check("R5 output held again", 1'b1, 18'h0ABCD);
        // R10: asynchronous output enable during freeze
        oe_n = 1'b1;
        #1;
        check("R10 oe_n forces off", 1'b0, '0);
        oe_n = 1'b0;
        #1;
        check("R10 data returns", 1'b1, 18'h0ABCD);
        clk_en_n = 1'b0;
        cyc(SEL, 1'b0, 1'b1, 2'b11, 10'd6, '0);
        cyc(3'b110, 1'b0, 1'b1, 2'b11, 10'd0, '0);
        cyc(3'b110, 1'b0, 1'b1, 2'b11, 10'd0, '0);
        check("R5 frozen write left memory unchanged", 1'b1, 18'h0ABCD);

        // R9: linear write burst from 9 -> 9,10,11,8
        burst_ilv = 1'b0;
        cyc(SEL, 1'b0, 1'b0, 2'b00, 10'd9, '0);
        cyc(SEL, 1'b1, 1'b1, 2'b00, 10'd0, '0);
        cyc(SEL, 1'b1, 1'b1, 2'b00, 10'd0, 18'h2A001);
        cyc(SEL, 1'b1, 1'b1, 2'b00, 10'd0, 18'h15002);
        cyc(3'b110, 1'b0, 1'b1, 2'b11, 10'd0, 18'h3C003);
        cyc(3'b110, 1'b0, 1'b1, 2'b11, 10'd0, 18'h00F04);
        // R9: interleaved read burst from 10 -> 10,11,8,9,10
        burst_ilv = 1'b1;
        cyc(SEL, 1'b0, 1'b1, 2'b11, 10'd10, '0);
        cyc(SEL, 1'b1, 1'b0, 2'b11, 10'd0, '0);
        cyc(SEL, 1'b1, 1'b0, 2'b11, 10'd0, '0);
        check("R9 burst word 0", 1'b1, 18'h15002);
        cyc(SEL, 1'b1, 1'b0, 2'b11, 10'd0, '0);
        check("R9 burst word 1", 1'b1, 18'h3C003);
        cyc(SEL, 1'b1, 1'b0, 2'b11, 10'd0, '0);
        check("R9 burst word 2", 1'b1, 18'h00F04);
        cyc(3'b110, 1'b0, 1'b1, 2'b11, 10'd0, '0);
        check("R9 burst word 3", 1'b1, 18'h2A001);
        cyc(3'b110, 1'b0, 1'b1, 2'b11, 10'd0, '0);
        check("R9 burst wraps", 1'b1, 18'h15002);

        // R6: deselect ends a burst; later advances do nothing
        cyc(SEL, 1'b0, 1'b1, 2'b11, 10'd10, '0);
        cyc(3'b011, 1'b0, 1'b1, 2'b11, 10'd0, '0);
        cyc(SEL, 1'b1, 1'b1, 2'b11, 10'd0, '0);
        check("R6 first word before deselect", 1'b1, 18'h15002);
        cyc(SEL, 1'b1, 1'b1, 2'b11, 10'd0, '0);
        check("R6 deselect stops burst", 1'b0, '0);
        cyc(SEL, 1'b1, 1'b1, 2'b11, 10'd0, '0);
        check("R6 advance after deselect idle", 1'b0, '0);
        cyc(SEL, 1'b1, 1'b1, 2'b11, 10'd0, '0);
        check("R6 advance after deselect still idle", 1'b0, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule